// File: doc/BRIEF.md
# Clock-Calendar Counter with Selectable Number Format

This block keeps the time of day and the calendar: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A one-second strobe from a divider outside the block advances the time by one second. Two copies of the time are held. The working copy always counts. The user-visible copy is the one presented on the outputs, and it is refreshed from the working copy at the end of each update, unless the host has frozen it.

Two controls set how the bytes are shown. The first picks binary or BCD for every byte. The second picks a 24-hour clock or a 12-hour clock with a PM flag in the top bit of the hour byte. The host loads the time one byte at a time, and only while the user copy is frozen. An optional daylight-saving mode moves the clock forward one hour in spring and back one hour in autumn.

Each update walks a small state machine:
- ST_IDLE goes to ST_COUNT on a strobe.
- ST_COUNT adds one second with every carry and goes to ST_DST.
- ST_DST applies any daylight-saving jump and goes to ST_COPY.
- ST_COPY refreshes the user copy unless it is frozen, and goes to ST_DONE.
- ST_DONE raises the done pulse and returns to ST_IDLE.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read seconds 00h, minutes 00h, hour 00h, day of week 01h, day of month 01h, month 01h, year 00h, and `upd_done` is low.
- R2: Each `tick_1s` pulse sampled in the idle state adds one second. Seconds and minutes wrap 59 to 0 and carry into the next field. In 24-hour mode the hour counts 0 to 23.
- R3: `fmt_bin` = 1 presents every byte as a plain binary value. `fmt_bin` = 0 presents it as two BCD digits, tens in bits 7:4 and units in bits 3:0.
- R4: With `hour_24` = 0 the hour byte carries 1 to 12 in bits 6:0, and bit 7 is set for PM. Midnight reads 12h (BCD) or 0Ch (binary). Noon reads 92h (BCD) or 8Ch (binary).
- R5: Day of week counts 1 to 7, where 1 is Sunday, and wraps 7 to 1 at midnight.
- R6: Day of month wraps after the month's last day. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4, including year 0, and 28 days otherwise. All other months have 31 days. The host loads only valid dates.
- R7: Month wraps 12 to 1 and carries into the year. The year wraps 99 to 0.
- R8: While `hold_xfer` = 1 the outputs keep their values across updates, but the working copy still counts. On the first update after `hold_xfer` returns to 0, the outputs show the working time.
- R9: In the idle state, a write with `wr_en` = 1 and `hold_xfer` = 1 takes effect as follows:
  - `wr_data` goes to the field picked by `wr_sel` (0 seconds, 1 minutes, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year).
  - The byte is decoded in the current format and mode into the working copy.
  - The byte is stored as written in the user copy.
  - The byte is visible on the outputs one cycle after the write.
- R10: A write made while `hold_xfer` = 0 changes neither copy.
- R11: With `dst_en` = 1, on a Sunday in April with day of month at most 7, the step from 1:59:59 gives 3:00:00.
- R12: With `dst_en` = 1, on a Sunday in October with day of month at least 25, the first step from 1:59:59 gives 1:00:00. Later steps past 1:59:59 on that day give 2:00:00.
- R13: `upd_done` is high for exactly one cycle, in the fourth cycle after the cycle in which `tick_1s` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1s | input | 1 | One-second update strobe |
| fmt_bin | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hour_24 | input | 1 | 1 = 24-hour mode, 0 = 12-hour mode with PM flag |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| hold_xfer | input | 1 | Freezes the user copy and enables host writes |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Byte to write, in the current format |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hour byte |
| dow_o | output | 8 | Day-of-week byte |
| dom_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |
| upd_done | output | 1 | One-cycle pulse at the end of each update |

## Verification
The bench targets the cascades where one step changes every field at once:
- New Year's Eve at year 99, where a design missing a carry would leave a field unchanged.
- February 28 and 29 in leap and common years, including year 0, where a wrong month-length rule would skip or add a day.

In 12-hour mode it steps across noon and midnight. A flawed encoder there would show hour 0, or misplace the PM flag.

It also covers the frozen user copy and a write refused while unfrozen. An error there would let the outputs move or take the stray byte.

Both daylight-saving jumps are tested, and the second 1:59:59 on the autumn Sunday is revisited. A design that forgot the fall-back had already happened would loop back to 1:00:00 a second time.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int BYTE_W    = 8;
    localparam int VAL_W     = 7;
    localparam int NFIELD    = 7;
    localparam int SEL_W     = 3;

    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_DOW = 3;
    localparam int F_DOM = 4;
    localparam int F_MON = 5;
    localparam int F_YR  = 6;

    localparam int SEC_LIM  = 60;
    localparam int MIN_LIM  = 60;
    localparam int HR_LIM   = 24;
    localparam int HALF_DAY = 12;
    localparam int WEEK_LEN = 7;
    localparam int MON_LIM  = 12;
    localparam int YR_LIM   = 100;

    localparam int DST_SPRING_MON  = 4;
    localparam int DST_FALL_MON    = 10;
    localparam int DST_HOUR        = 2;
    localparam int SUNDAY          = 1;
    localparam int FIRST_WEEK_LAST = 7;
    localparam int LAST_WEEK_FIRST = 25;

    typedef logic [NFIELD-1:0][VAL_W-1:0]  tvec_t;
    typedef logic [NFIELD-1:0][BYTE_W-1:0] bvec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_DST,
        ST_COPY,
        ST_DONE
    } upd_state_t;

    function automatic logic [VAL_W-1:0] month_days(input logic [VAL_W-1:0] mon,
                                                    input logic [VAL_W-1:0] yr);
        logic [VAL_W-1:0] d;
        case (mon)
            7'd2:                   d = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11: d = 7'd30;
            default:                d = 7'd31;
        endcase
        return d;
    endfunction

    function automatic logic [BYTE_W-1:0] to_bcd(input logic [VAL_W-1:0] v);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return {tens, ones};
    endfunction

    function automatic logic [VAL_W-1:0] from_bcd(input logic [BYTE_W-1:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction
endpackage

// File: rtl/rtc_next_sec.sv
module rtc_next_sec
    import rtc_cal_pkg::*;
(
    input  tvec_t cur,
    output tvec_t nxt
);
    logic [VAL_W-1:0] last_day;

    assign last_day = month_days(cur[F_MON], cur[F_YR]);

    always_comb begin
        nxt = cur;
        if (cur[F_SEC] != VAL_W'(SEC_LIM - 1)) begin
            nxt[F_SEC] = cur[F_SEC] + 7'd1;
        end else begin
            nxt[F_SEC] = '0;
            if (cur[F_MIN] != VAL_W'(MIN_LIM - 1)) begin
                nxt[F_MIN] = cur[F_MIN] + 7'd1;
            end else begin
                nxt[F_MIN] = '0;
                if (cur[F_HR] != VAL_W'(HR_LIM - 1)) begin
                    nxt[F_HR] = cur[F_HR] + 7'd1;
                end else begin
                    nxt[F_HR]  = '0;
                    nxt[F_DOW] = (cur[F_DOW] >= VAL_W'(WEEK_LEN)) ? 7'd1 : cur[F_DOW] + 7'd1;
                    if (cur[F_DOM] < last_day) begin
                        nxt[F_DOM] = cur[F_DOM] + 7'd1;
                    end else begin
                        nxt[F_DOM] = 7'd1;
                        if (cur[F_MON] < VAL_W'(MON_LIM)) begin
                            nxt[F_MON] = cur[F_MON] + 7'd1;
                        end else begin
                            nxt[F_MON] = 7'd1;
                            nxt[F_YR]  = (cur[F_YR] >= VAL_W'(YR_LIM - 1)) ? '0 : cur[F_YR] + 7'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_dst_adj.sv
module rtc_dst_adj
    import rtc_cal_pkg::*;
(
    input  tvec_t t_in,
    input  logic  dst_en,
    input  logic  fell_q,
    output tvec_t t_out,
    output logic  fell_d
);
    logic on_hour_mark;
    logic on_sunday;
    logic at_midnight;
    logic spring_hit;
    logic fall_hit;

    assign on_hour_mark = (t_in[F_HR] == VAL_W'(DST_HOUR)) && (t_in[F_MIN] == '0) && (t_in[F_SEC] == '0);
    assign at_midnight  = (t_in[F_HR] == '0) && (t_in[F_MIN] == '0) && (t_in[F_SEC] == '0);
    assign on_sunday    = (t_in[F_DOW] == VAL_W'(SUNDAY));
    assign spring_hit   = dst_en && on_sunday && on_hour_mark &&
                          (t_in[F_MON] == VAL_W'(DST_SPRING_MON)) &&
                          (t_in[F_DOM] <= VAL_W'(FIRST_WEEK_LAST));
    assign fall_hit     = dst_en && on_sunday && on_hour_mark && !fell_q &&
                          (t_in[F_MON] == VAL_W'(DST_FALL_MON)) &&
                          (t_in[F_DOM] >= VAL_W'(LAST_WEEK_FIRST));

    always_comb begin
        t_out  = t_in;
        fell_d = fell_q;
        if (spring_hit) begin
            t_out[F_HR] = VAL_W'(DST_HOUR + 1);
        end
        if (fall_hit) begin
            t_out[F_HR] = VAL_W'(DST_HOUR - 1);
            fell_d      = 1'b1;
        end
        if (at_midnight) begin
            fell_d = 1'b0;
        end
    end
endmodule

// File: rtl/rtc_byte_enc.sv
module rtc_byte_enc
    import rtc_cal_pkg::*;
(
    input  tvec_t t_in,
    input  logic  fmt_bin,
    input  logic  hour_24,
    output bvec_t bytes
);
    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        if (i == F_HR) begin : g_hour
            logic             is_pm;
            logic [VAL_W-1:0] h12;
            logic [VAL_W-1:0] shown;
            logic [BYTE_W-1:0] code;
            always_comb begin
                is_pm = (t_in[i] >= VAL_W'(HALF_DAY));
                if (t_in[i] == '0)
                    h12 = VAL_W'(HALF_DAY);
                else if (t_in[i] > VAL_W'(HALF_DAY))
                    h12 = t_in[i] - VAL_W'(HALF_DAY);
                else
                    h12 = t_in[i];
                shown = hour_24 ? t_in[i] : h12;
                code  = fmt_bin ? {1'b0, shown} : to_bcd(shown);
                bytes[i] = (!hour_24 && is_pm) ? {1'b1, code[BYTE_W-2:0]} : code;
            end
        end else begin : g_plain
            always_comb begin
                bytes[i] = fmt_bin ? {1'b0, t_in[i]} : to_bcd(t_in[i]);
            end
        end
    end
endmodule

// File: rtl/rtc_byte_dec.sv
module rtc_byte_dec
    import rtc_cal_pkg::*;
(
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [SEL_W-1:0]  sel,
    input  logic              fmt_bin,
    input  logic              hour_24,
    output logic [VAL_W-1:0]  val
);
    logic              hr12;
    logic [BYTE_W-1:0] body;
    logic [VAL_W-1:0]  mag;

    always_comb begin
        hr12 = (sel == SEL_W'(F_HR)) && !hour_24;
        body = hr12 ? {1'b0, wbyte[BYTE_W-2:0]} : wbyte;
        mag  = fmt_bin ? body[VAL_W-1:0] : from_bcd(body);
        if (!hr12)
            val = mag;
        else if (mag == VAL_W'(HALF_DAY))
            val = wbyte[BYTE_W-1] ? VAL_W'(HALF_DAY) : '0;
        else
            val = wbyte[BYTE_W-1] ? mag + VAL_W'(HALF_DAY) : mag;
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1s,
    input  logic        fmt_bin,
    input  logic        hour_24,
    input  logic        dst_en,
    input  logic        hold_xfer,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic [7:0]  sec_o,
    output logic [7:0]  min_o,
    output logic [7:0]  hour_o,
    output logic [7:0]  dow_o,
    output logic [7:0]  dom_o,
    output logic [7:0]  mon_o,
    output logic [7:0]  year_o,
    output logic        upd_done
);
    upd_state_t        st_q, st_d;
    tvec_t             wk_q, step_t, adj_t;
    bvec_t             usr_q, enc_b;
    logic              fell_q, fell_nx;
    logic [VAL_W-1:0]  wr_val;
    logic              sel_ok;
    logic              wr_fire;

    assign sel_ok  = int'(wr_sel) < NFIELD;
    assign wr_fire = wr_en && hold_xfer && sel_ok && (st_q == ST_IDLE);

    rtc_next_sec u_next (.cur(wk_q), .nxt(step_t));

    rtc_dst_adj u_dst (
        .t_in(wk_q), .dst_en(dst_en), .fell_q(fell_q),
        .t_out(adj_t), .fell_d(fell_nx)
    );

    rtc_byte_enc u_enc (
        .t_in(wk_q), .fmt_bin(fmt_bin), .hour_24(hour_24), .bytes(enc_b)
    );

    rtc_byte_dec u_dec (
        .wbyte(wr_data), .sel(wr_sel), .fmt_bin(fmt_bin),
        .hour_24(hour_24), .val(wr_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (tick_1s) st_d = ST_COUNT;
            ST_COUNT: st_d = ST_DST;
            ST_DST:   st_d = ST_COPY;
            ST_COPY:  st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // working copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q         <= '0;
            wk_q[F_DOW]  <= 7'd1;
            wk_q[F_DOM]  <= 7'd1;
            wk_q[F_MON]  <= 7'd1;
            fell_q       <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (wr_fire) wk_q[wr_sel] <= wr_val;
                ST_COUNT: wk_q <= step_t;
                ST_DST: begin
                    wk_q   <= adj_t;
                    fell_q <= fell_nx;
                end
                default: ;
            endcase
        end
    end

    // user copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            usr_q        <= '0;
            usr_q[F_DOW] <= 8'h01;
            usr_q[F_DOM] <= 8'h01;
            usr_q[F_MON] <= 8'h01;
        end else if (wr_fire) begin
            usr_q[wr_sel] <= wr_data;
        end else if (st_q == ST_COPY && !hold_xfer) begin
            usr_q <= enc_b;
        end
    end

    // outputs
    always_comb begin
        upd_done = (st_q == ST_DONE);
        sec_o    = usr_q[F_SEC];
        min_o    = usr_q[F_MIN];
        hour_o   = usr_q[F_HR];
        dow_o    = usr_q[F_DOW];
        dom_o    = usr_q[F_DOM];
        mon_o    = usr_q[F_MON];
        year_o   = usr_q[F_YR];
    end

    // R13
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COPY && hold_xfer) |=> $stable(usr_q));

    // R10
    wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && wr_en && !hold_xfer) |=> $stable(usr_q));

    // R6
    dom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DST) |-> (wk_q[F_DOM] >= 7'd1 &&
                              wk_q[F_DOM] <= month_days(wk_q[F_MON], wk_q[F_YR])));

    // R4
    hr12_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !$past(hour_24) && !$past(hold_xfer)) |-> (hour_o[6:0] != 7'd0));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COUNT) |=> (wk_q[F_SEC] == (($past(wk_q[F_SEC]) == 7'd59) ? 7'd0 : $past(wk_q[F_SEC]) + 7'd1)));
endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       fmt_bin = 1'b0;
    logic       hour_24 = 1'b1;
    logic       dst_en = 1'b0;
    logic       hold_xfer = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o;
    logic       upd_done;

    int nchk = 0;
    int nerr = 0;
    int m [7];
    bit mfell = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .fmt_bin(fmt_bin),
        .hour_24(hour_24), .dst_en(dst_en), .hold_xfer(hold_xfer),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .dom_o(dom_o), .mon_o(mon_o), .year_o(year_o), .upd_done(upd_done)
    );

    function automatic int mdays(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] benc(int idx, int v, bit fb, bit h24);
        int val;
        bit pm;
        logic [7:0] r;
        val = v;
        pm  = 1'b0;
        if (idx == 2 && !h24) begin
            pm  = (v >= 12);
            val = v % 12;
            if (val == 0) val = 12;
        end
        r = fb ? 8'(val) : 8'((val / 10) * 16 + val % 10);
        if (pm) r[7] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] dout(int idx);
        case (idx)
            0: return sec_o;
            1: return min_o;
            2: return hour_o;
            3: return dow_o;
            4: return dom_o;
            5: return mon_o;
            default: return year_o;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 7; i++) chk(req, dout(i), benc(i, m[i], fmt_bin, hour_24));
    endtask

    task automatic model_step();
        m[0]++;
        if (m[0] == 60) begin
            m[0] = 0; m[1]++;
            if (m[1] == 60) begin
                m[1] = 0; m[2]++;
                if (m[2] == 24) begin
                    m[2] = 0;
                    m[3] = (m[3] == 7) ? 1 : m[3] + 1;
                    if (m[4] == mdays(m[5], m[6])) begin
                        m[4] = 1;
                        if (m[5] == 12) begin
                            m[5] = 1;
                            m[6] = (m[6] == 99) ? 0 : m[6] + 1;
                        end else m[5]++;
                    end else m[4]++;
                end
            end
        end
        if (dst_en && m[3] == 1 && m[2] == 2 && m[1] == 0 && m[0] == 0) begin
            if (m[5] == 4 && m[4] <= 7) m[2] = 3;
            else if (m[5] == 10 && m[4] >= 25 && !mfell) begin
                m[2] = 1;
                mfell = 1'b1;
            end
        end
        if (m[2] == 0 && m[1] == 0 && m[0] == 0) mfell = 1'b0;
    endtask

    // one update; checks the done pulse timing (R13) and steps the model
    task automatic do_tick();
        @(negedge clk) tick_1s = 1'b1;
        @(negedge clk) tick_1s = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13 done low before", 8'(upd_done), 8'h00);
        @(negedge clk);
        chk("R13 done high", 8'(upd_done), 8'h01);
        @(negedge clk);
        chk("R13 done single", 8'(upd_done), 8'h00);
        model_step();
    endtask

    task automatic wr_byte(int sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(int s, int mi, int h, int dw, int dm, int mo, int y, bit keep_hold);
        m[0] = s; m[1] = mi; m[2] = h; m[3] = dw; m[4] = dm; m[5] = mo; m[6] = y;
        @(negedge clk) hold_xfer = 1'b1;
        for (int i = 6; i >= 0; i--) wr_byte(i, benc(i, m[i], fmt_bin, hour_24));
        if (!keep_hold) begin
            @(negedge clk) hold_xfer = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        m = '{0, 0, 0, 1, 1, 1, 0};
        check_all("R1");
        chk("R1 done", 8'(upd_done), 8'h00);

        // R2 R5 R7: binary and BCD new-year cascade
        for (int f = 0; f < 2; f++) begin
            fmt_bin = f[0];
            set_time(59, 59, 23, 7, 31, 12, 99, 1'b0);
            check_all("R9 load");
            do_tick();
            check_all("R7 R5 R2 rollover");
            chk("R3 year", year_o, 8'h00);
            chk("R5 dow", dow_o, 8'h01);
        end

        // R3 explicit BCD encoding
        fmt_bin = 1'b0;
        set_time(58, 45, 19, 3, 17, 8, 37, 1'b0);
        do_tick();
        chk("R3 bcd sec", sec_o, 8'h59);
        chk("R3 bcd hour", hour_o, 8'h19);
        chk("R3 bcd year", year_o, 8'h37);

        // R6 leap years and month lengths
        set_time(59, 59, 23, 2, 28, 2, 0, 1'b0);
        do_tick(); check_all("R6 leap 00");
        chk("R6 feb29", dom_o, 8'h29);
        set_time(59, 59, 23, 2, 28, 2, 1, 1'b0);
        do_tick(); check_all("R6 common");
        chk("R6 mar1", mon_o, 8'h03);
        fmt_bin = 1'b1;
        set_time(59, 59, 23, 2, 29, 2, 24, 1'b0);
        do_tick(); check_all("R6 leap end");
        set_time(59, 59, 23, 4, 30, 4, 50, 1'b0);
        do_tick(); check_all("R6 april");
        chk("R6 may", mon_o, 8'h05);

        // R4 12-hour mode
        hour_24 = 1'b0;
        for (int f = 0; f < 2; f++) begin
            fmt_bin = f[0];
            set_time(59, 59, 11, 1, 1, 1, 1, 1'b0);
            do_tick();
            chk("R4 noon", hour_o, f ? 8'h8C : 8'h92);
            set_time(59, 59, 23, 1, 1, 1, 1, 1'b0);
            do_tick();
            chk("R4 midnight", hour_o, f ? 8'h0C : 8'h12);
            do_tick();
            check_all("R4 after midnight");
        end
        hour_24 = 1'b1;

        // R8 hold freezes user copy, working keeps counting
        fmt_bin = 1'b0;
        set_time(10, 20, 5, 4, 9, 6, 12, 1'b1);
        chk("R9 direct", sec_o, 8'h10);
        for (int k = 0; k < 3; k++) begin
            do_tick();
            chk("R8 frozen", sec_o, 8'h10);
        end
        @(negedge clk) hold_xfer = 1'b0;
        do_tick();
        check_all("R8 released");
        chk("R8 sec", sec_o, 8'h14);

        // R10 write ignored without hold
        wr_byte(0, 8'h33);
        chk("R10 out", sec_o, 8'h14);
        do_tick();
        check_all("R10 working");

        // R11 spring forward
        dst_en = 1'b1;
        set_time(59, 59, 1, 1, 5, 4, 20, 1'b0);
        do_tick();
        chk("R11 jump", hour_o, 8'h03);
        check_all("R11");
        set_time(59, 59, 1, 2, 5, 4, 20, 1'b0);
        do_tick();
        chk("R11 weekday", hour_o, 8'h02);

        // R12 fall back once
        set_time(59, 59, 1, 1, 28, 10, 20, 1'b0);
        do_tick();
        chk("R12 back", hour_o, 8'h01);
        @(negedge clk) hold_xfer = 1'b1;
        m[0] = 59; m[1] = 59;
        wr_byte(1, 8'h59);
        wr_byte(0, 8'h59);
        @(negedge clk) hold_xfer = 1'b0;
        do_tick();
        chk("R12 once", hour_o, 8'h02);
        check_all("R12");
        dst_en = 1'b0;

        // random mix
        for (int it = 0; it < 40; it++) begin
            int s, mi, h, dm, mo, y, n;
            fmt_bin = 1'($urandom_range(1, 0));
            hour_24 = 1'($urandom_range(1, 0));
            y  = $urandom_range(99, 0);
            mo = $urandom_range(12, 1);
            dm = ($urandom_range(1, 0) == 1) ? mdays(mo, y) : $urandom_range(mdays(mo, y), 1);
            h  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
            mi = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
            s  = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
            set_time(s, mi, h, $urandom_range(7, 1), dm, mo, y, 1'b0);
            n = $urandom_range(3, 1);
            for (int k = 0; k < n; k++) begin
                do_tick();
                check_all("R2 R3 random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule